// File: doc/BRIEF.md
# Prescaled Local Timebase Counter

This block produces the free-running timebase count that the per-core timers of a cluster compare against. Every cycle it looks at one of two clock-enable strobes: one paced by the crystal, the other by an alternate source. A strobe feeds a fractional rate divider. Each tick of the divider advances the count by one or by two, as the control register selects.

The divider rate is set by a prescaler register. The counting rate equals the strobe rate times 2^31 divided by the prescaler value. A prescaler of 0x8000_0000 gives one tick per strobe, and larger values slow the count down in fine fractional steps. Software reaches the control, the prescaler and the two halves of the count through a small word-addressed register bus. Reading the low half of the count captures the high half in the same cycle, so that a two-word read yields a consistent value. The full count is also driven on a port for the compare logic, which lies outside this block.

Top module: `tbc_timebase`

## Requirements
- R1: After reset, the control register reads 0, the prescaler reads 0x8000_0000 and the count is 0.
- R2: Control bit 8 picks the strobe. With 0 only `xtal_stb` advances the divider and `alt_stb` has no effect; with 1 the roles are swapped.
- R3: Control bit 9 picks the step. With 0 each tick adds 1 to the count; with 1 each tick adds 2. All other control bits read back as 0.
- R4: For a prescaler P of 2^31 or above, each selected strobe adds 2^31 to a remainder. When the remainder reaches P, one tick is issued and P is subtracted. After n strobes from a cleared remainder there are floor(n*2^31/P) ticks, so P = 0xC000_0000 gives two ticks in every three strobes.
- R5: With P = 0x8000_0000 every selected strobe produces exactly one tick.
- R6: A nonzero P below 2^31 is treated as 2^31, which gives one tick per strobe and never more.
- R7: With P = 0 the count holds its value whatever the strobes do.
- R8: A write to the prescaler clears the remainder. A strobe in the same cycle as that write produces no tick.
- R9: A tick caused by a strobe sampled at a clock edge shows on `count_o` after that same edge. Control and prescaler writes take effect from the following cycle.
- R10: Word 2 returns the low half of the count. A read of word 2 captures the high half at that edge, and word 3 returns that captured value.
- R11: Word 0 is the control register and word 1 the prescaler. Writes to words 2 and 3 are ignored. Read data is combinational from `reg_addr` during the cycle in which `reg_rd` is high, and 0 otherwise.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| xtal_stb | input | 1 | Crystal-paced clock-enable strobe |
| alt_stb | input | 1 | Alternate-source clock-enable strobe |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe |
| reg_addr | input | 2 | Word index: 0 control, 1 prescaler, 2 count low, 3 count high |
| reg_wdata | input | BUS_W | Write data |
| reg_rdata | output | BUS_W | Read data |
| count_o | output | 2*BUS_W | Timebase count |

## Verification
A strobe sampled at an edge changes `count_o` after that same edge. The bench therefore drives inputs on the falling edge and compares the count on the next falling edge, once its model has processed the rising edge. Read data is due in the cycle of the read, so it is compared shortly after the inputs are driven and before the rising edge. The high-half capture becomes visible from the following cycle. The bench uses a 12-bit word, so the high half carries within a few thousand ticks and the capture is exercised on nonzero values.

// File: rtl/tbc_pkg.sv
package tbc_pkg;
  // word indices on the register bus
  localparam logic [1:0] ADDR_CTRL = 2'd0;
  localparam logic [1:0] ADDR_PRSC = 2'd1;
  localparam logic [1:0] ADDR_CLO  = 2'd2;
  localparam logic [1:0] ADDR_CHI  = 2'd3;
  // control bit positions (word must be at least 10 bits wide)
  localparam int CTRL_SRC_BIT  = 8;
  localparam int CTRL_STEP_BIT = 9;

  typedef struct packed {
    logic step2;
    logic src_alt;
  } tbc_ctrl_t;
endpackage

// File: rtl/tbc_regs.sv
module tbc_regs
  import tbc_pkg::*;
#(
  parameter int BUS_W = 32,
  localparam int CNT_W = 2 * BUS_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             reg_wr,
  input  logic             reg_rd,
  input  logic [1:0]       reg_addr,
  input  logic [BUS_W-1:0] reg_wdata,
  output logic [BUS_W-1:0] reg_rdata,
  input  logic [CNT_W-1:0] count,
  output tbc_ctrl_t        ctrl,
  output logic [BUS_W-1:0] prescale,
  output logic             prescale_wr
);
  localparam logic [BUS_W-1:0] UNITY = BUS_W'(1) << (BUS_W - 1);

  tbc_ctrl_t        ctrl_q, ctrl_d;
  logic [BUS_W-1:0] prsc_q, prsc_d;
  logic [BUS_W-1:0] hi_q, hi_d;
  logic             wr_ctrl, wr_prsc, rd_lo;

  always_comb begin
    wr_ctrl = reg_wr && (reg_addr == ADDR_CTRL);
    wr_prsc = reg_wr && (reg_addr == ADDR_PRSC);
    rd_lo   = reg_rd && (reg_addr == ADDR_CLO);
    ctrl_d  = ctrl_q;
    prsc_d  = prsc_q;
    hi_d    = hi_q;
    if (wr_ctrl) begin
      ctrl_d.src_alt = reg_wdata[CTRL_SRC_BIT];
      ctrl_d.step2   = reg_wdata[CTRL_STEP_BIT];
    end
    if (wr_prsc) prsc_d = reg_wdata;
    if (rd_lo)   hi_d   = count[CNT_W-1:BUS_W];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q <= '0;
      prsc_q <= UNITY;
      hi_q   <= '0;
    end else begin
      ctrl_q <= ctrl_d;
      prsc_q <= prsc_d;
      hi_q   <= hi_d;
    end
  end

  always_comb begin
    reg_rdata = '0;
    if (reg_rd) begin
      unique case (reg_addr)
        ADDR_CTRL: begin
          reg_rdata[CTRL_SRC_BIT]  = ctrl_q.src_alt;
          reg_rdata[CTRL_STEP_BIT] = ctrl_q.step2;
        end
        ADDR_PRSC: reg_rdata = prsc_q;
        ADDR_CLO:  reg_rdata = count[BUS_W-1:0];
        ADDR_CHI:  reg_rdata = hi_q;
        default:   reg_rdata = '0;
      endcase
    end
  end

  assign ctrl        = ctrl_q;
  assign prescale    = prsc_q;
  assign prescale_wr = wr_prsc;

  // R10: a low-word read captures the high half present at that edge
  assert_hi_capture_R10: assert property (@(posedge clk) disable iff (!rst_n)
    rd_lo |=> hi_q == $past(count[CNT_W-1:BUS_W]));
  // R9: a prescaler write is visible from the next cycle
  assert_prsc_write_R9: assert property (@(posedge clk) disable iff (!rst_n)
    wr_prsc |=> prsc_q == $past(reg_wdata));
  // R11: counter words are not writable, so high capture only moves on reads
  assert_hi_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_lo |=> $stable(hi_q));
endmodule

// File: rtl/tbc_rate.sv
module tbc_rate
  import tbc_pkg::*;
#(
  parameter int BUS_W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             xtal_stb,
  input  logic             alt_stb,
  input  logic             src_alt,
  input  logic [BUS_W-1:0] prescale,
  input  logic             prescale_wr,
  output logic             tick
);
  localparam logic [BUS_W:0] UNITY_X = (BUS_W+1)'(1) << (BUS_W - 1);

  logic [BUS_W-1:0] acc_q, acc_d;
  logic [BUS_W:0]   sum, div_eff;
  logic             stb_sel, run, reach;

  always_comb begin
    stb_sel = src_alt ? alt_stb : xtal_stb;
    run     = stb_sel && (prescale != '0) && !prescale_wr;
    div_eff = ({1'b0, prescale} < UNITY_X) ? UNITY_X : {1'b0, prescale};
    sum     = {1'b0, acc_q} + UNITY_X;
    reach   = (sum >= div_eff);
    acc_d   = acc_q;
    tick    = 1'b0;
    if (prescale_wr) begin
      acc_d = '0;
    end else if (run) begin
      if (reach) begin
        tick  = 1'b1;
        acc_d = BUS_W'(sum - div_eff);
      end else begin
        acc_d = sum[BUS_W-1:0];
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) acc_q <= '0;
    else if (prescale_wr || run) acc_q <= acc_d;
  end

  // R4: the remainder stays below the effective divisor
  assert_rem_bound_R4: assert property (@(posedge clk) disable iff (!rst_n)
    {1'b0, acc_q} < div_eff);
  // R7: a zero prescaler never ticks
  assert_zero_stop_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (prescale == '0) |-> !tick);
  // R2: a tick only follows the selected strobe
  assert_src_gate_R2: assert property (@(posedge clk) disable iff (!rst_n)
    tick |-> (src_alt ? alt_stb : xtal_stb));
  // R8: a prescaler write clears the remainder
  assert_rem_clear_R8: assert property (@(posedge clk) disable iff (!rst_n)
    prescale_wr |=> acc_q == '0);
endmodule

// File: rtl/tbc_count.sv
module tbc_count #(
  parameter int CNT_W = 64
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick,
  input  logic             step2,
  output logic [CNT_W-1:0] count
);
  logic [CNT_W-1:0] cnt_q, cnt_d, inc;

  always_comb begin
    inc   = step2 ? CNT_W'(2) : CNT_W'(1);
    cnt_d = cnt_q + inc;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    cnt_q <= '0;
    else if (tick) cnt_q <= cnt_d;
  end

  assign count = cnt_q;

  // R3: each tick adds the selected step
  assert_step_R3: assert property (@(posedge clk) disable iff (!rst_n)
    tick |=> cnt_q == $past(cnt_q) + ($past(step2) ? CNT_W'(2) : CNT_W'(1)));
  // R9: no tick, no change
  assert_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !tick |=> $stable(cnt_q));
endmodule

// File: rtl/tbc_timebase.sv
module tbc_timebase
  import tbc_pkg::*;
#(
  parameter int BUS_W = 32,
  localparam int CNT_W = 2 * BUS_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             xtal_stb,
  input  logic             alt_stb,
  input  logic             reg_wr,
  input  logic             reg_rd,
  input  logic [1:0]       reg_addr,
  input  logic [BUS_W-1:0] reg_wdata,
  output logic [BUS_W-1:0] reg_rdata,
  output logic [CNT_W-1:0] count_o
);
  logic [1:0]       rst_sync;
  logic             rst_int_n;
  tbc_ctrl_t        ctrl;
  logic [BUS_W-1:0] prescale;
  logic             prescale_wr;
  logic             tick;

  // asynchronous assertion, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync <= 2'b00;
    else        rst_sync <= {rst_sync[0], 1'b1};
  end
  assign rst_int_n = rst_sync[1];

  tbc_regs #(.BUS_W(BUS_W)) u_regs (
    .clk(clk), .rst_n(rst_int_n),
    .reg_wr(reg_wr), .reg_rd(reg_rd), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .count(count_o), .ctrl(ctrl),
    .prescale(prescale), .prescale_wr(prescale_wr)
  );

  tbc_rate #(.BUS_W(BUS_W)) u_rate (
    .clk(clk), .rst_n(rst_int_n),
    .xtal_stb(xtal_stb), .alt_stb(alt_stb),
    .src_alt(ctrl.src_alt), .prescale(prescale),
    .prescale_wr(prescale_wr), .tick(tick)
  );

  tbc_count #(.CNT_W(CNT_W)) u_count (
    .clk(clk), .rst_n(rst_int_n),
    .tick(tick), .step2(ctrl.step2), .count(count_o)
  );

  // R5: at the unity prescaler the selected strobe always ticks
  assert_unity_R5: assert property (@(posedge clk) disable iff (!rst_int_n)
    (prescale == (BUS_W'(1) << (BUS_W - 1)) && !prescale_wr &&
     (ctrl.src_alt ? alt_stb : xtal_stb)) |=> count_o != $past(count_o));
  // R6: small nonzero prescalers give at most one step per cycle
  assert_clamp_R6: assert property (@(posedge clk) disable iff (!rst_int_n)
    ##1 (count_o - $past(count_o)) <= CNT_W'(2));
endmodule

// File: tb/tbc_timebase_bench.sv
module tbc_timebase_bench;
  localparam int BW = 12;
  localparam int CW = 2 * BW;
  localparam logic [BW-1:0] UNI = BW'(1) << (BW - 1);

  logic clk = 1'b0, rst_n = 1'b0;
  logic xtal_stb = 0, alt_stb = 0, reg_wr = 0, reg_rd = 0;
  logic [1:0] reg_addr = 0;
  logic [BW-1:0] reg_wdata = 0, reg_rdata;
  logic [CW-1:0] count_o;

  int n_chk = 0, n_fail = 0;
  bit done = 0;

  logic          m_src, m_step;
  logic [BW-1:0] m_prsc, m_acc, m_hi;
  logic [CW-1:0] m_cnt;

  always #4 clk = ~clk;

  tbc_timebase #(.BUS_W(BW)) u_tbc_timebase (
    .clk(clk), .rst_n(rst_n), .xtal_stb(xtal_stb), .alt_stb(alt_stb),
    .reg_wr(reg_wr), .reg_rd(reg_rd), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .count_o(count_o)
  );

  task automatic chk(string req, logic [CW-1:0] act, logic [CW-1:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [BW-1:0] exp_rd(logic [1:0] a);
    logic [BW-1:0] v = '0;
    case (a)
      2'd0: begin v[8] = m_src; v[9] = m_step; end
      2'd1: v = m_prsc;
      2'd2: v = m_cnt[BW-1:0];
      default: v = m_hi;
    endcase
    return v;
  endfunction

  // one clock cycle; called on a falling edge
  task automatic cyc(bit wr, bit rd, logic [1:0] a, logic [BW-1:0] wd,
                     bit xs, bit as, string req);
    logic [BW:0] eff, s;
    bit st;
    reg_wr = wr; reg_rd = rd; reg_addr = a; reg_wdata = wd;
    xtal_stb = xs; alt_stb = as;
    #1;
    if (rd) chk({req, " R11 rdata"}, CW'(reg_rdata), CW'(exp_rd(a)));
    @(posedge clk);
    st = m_src ? as : xs;
    if (rd && a == 2'd2) m_hi = m_cnt[CW-1:BW];
    if (wr && a == 2'd1) begin
      m_prsc = wd; m_acc = '0;
    end else if (st && m_prsc != 0) begin
      eff = ({1'b0, m_prsc} < {1'b0, UNI}) ? {1'b0, UNI} : {1'b0, m_prsc};
      s = {1'b0, m_acc} + {1'b0, UNI};
      if (s >= eff) begin
        m_acc = BW'(s - eff);
        m_cnt = m_cnt + (m_step ? CW'(2) : CW'(1));
      end else m_acc = s[BW-1:0];
    end
    if (wr && a == 2'd0) begin m_src = wd[8]; m_step = wd[9]; end
    @(negedge clk);
    chk({req, " R9 count"}, count_o, m_cnt);
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) cyc(0, 0, 0, 0, 0, 0, "idle");
  endtask

  initial begin
    #400000;
    n_fail++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    logic [CW-1:0] base;
    m_src = 0; m_step = 0; m_prsc = UNI; m_acc = 0; m_hi = 0; m_cnt = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    // R1 reset values
    cyc(0, 1, 0, 0, 0, 0, "R1");
    cyc(0, 1, 1, 0, 0, 0, "R1");
    chk("R1 count", count_o, '0);
    // R5 unity: each crystal strobe ticks
    for (int i = 0; i < 8; i++) cyc(0, 0, 0, 0, 1, 0, "R5");
    chk("R5 eight ticks", count_o, CW'(8));
    // R2 alternate strobe ignored while crystal selected
    for (int i = 0; i < 5; i++) cyc(0, 0, 0, 0, 0, 1, "R2");
    chk("R2 alt ignored", count_o, CW'(8));
    cyc(1, 0, 0, BW'(1) << 8, 0, 0, "R2");
    for (int i = 0; i < 5; i++) cyc(0, 0, 0, 0, 1, 0, "R2");
    chk("R2 xtal ignored", count_o, CW'(8));
    for (int i = 0; i < 4; i++) cyc(0, 0, 0, 0, 0, 1, "R2");
    chk("R2 alt counts", count_o, CW'(12));
    // R3 step of two, other control bits read as zero
    cyc(1, 0, 0, '1, 0, 0, "R3");
    cyc(0, 1, 0, 0, 0, 0, "R3");
    for (int i = 0; i < 3; i++) cyc(0, 0, 0, 0, 0, 1, "R3");
    chk("R3 step two", count_o, CW'(18));
    cyc(1, 0, 0, 0, 0, 0, "R3");
    // R4 fractional 2/3 rate (P = 0xC00 scaled)
    cyc(1, 0, 1, BW'(3) << (BW - 2), 0, 0, "R4");
    base = count_o;
    for (int i = 0; i < 30; i++) cyc(0, 0, 0, 0, 1, 0, "R4");
    chk("R4 two of three", count_o - base, CW'(20));
    // R8 write with strobe: no tick, remainder cleared
    cyc(1, 0, 1, BW'(3) << (BW - 2), 1, 0, "R8");
    chk("R8 no tick", count_o - base, CW'(20));
    cyc(0, 0, 0, 0, 1, 0, "R8");
    chk("R8 first strobe no tick", count_o - base, CW'(20));
    // R6 small prescaler clamps to one per strobe
    cyc(1, 0, 1, BW'(5), 0, 0, "R6");
    base = count_o;
    for (int i = 0; i < 10; i++) cyc(0, 0, 0, 0, 1, 0, "R6");
    chk("R6 clamp", count_o - base, CW'(10));
    // R7 zero prescaler stops
    cyc(1, 0, 1, 0, 0, 0, "R7");
    base = count_o;
    for (int i = 0; i < 10; i++) cyc(0, 0, 0, 0, 1, 1, "R7");
    chk("R7 stopped", count_o, base);
    // R11 counter words ignore writes
    cyc(1, 0, 2, '1, 0, 0, "R11");
    cyc(1, 0, 3, '1, 0, 0, "R11");
    chk("R11 count unchanged", count_o, base);
    // R10 run into the high half, then read both words
    cyc(1, 0, 1, UNI, 0, 0, "R10");
    cyc(1, 0, 0, BW'(1) << 9, 0, 0, "R10");
    for (int i = 0; i < 2100; i++) cyc(0, 0, 0, 0, 1, 0, "R10");
    cyc(0, 1, 2, 0, 1, 0, "R10");
    cyc(0, 1, 3, 0, 1, 0, "R10");
    chk("R10 high captured", CW'(reg_rdata), CW'(m_hi));
    // random mix
    for (int i = 0; i < 4000; i++) begin
      int r = int'($urandom % 100);
      logic [BW-1:0] wd = BW'($urandom);
      logic [1:0] a = 2'($urandom);
      bit wr = (r < 6), rd = (r >= 50);
      if (wr && a == 2'd1 && r < 3) wd = wd | UNI;
      cyc(wr, rd, a, wd, 1'($urandom), 1'($urandom), "R4 random");
    end
    idle(2);
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
  end
endmodule